// File: doc/BRIEF.md
# Periodic Snapshot FIFO with Freeze

This block keeps a host-readable copy of a device-side status record. At a programmable interval, counted in base sample ticks, it pulls one record of `REC_LEN` bytes from the device over a valid/ready byte stream and stores it in a small FIFO. The FIFO never holds more than one record. The host polls the FIFO through a four-offset register port. Offset 0 holds a signed rate code. Offset 1 holds the freeze control. Reading offset 2 pops one data byte, and offset 3 returns a status byte.

The interval is a power of two of sample ticks. Updates happen only when the rate code is negative. A positive code only raises a mode flag for a transfer path that lives elsewhere, and zero switches updates off. To take a consistent record, the host sets freeze and then waits for busy to clear. A copy that has already started always runs to completion. No new copy begins while freeze is set.

The record stream uses back-pressure. `rec_ready` is high only while a copy is in progress. A byte moves on each cycle where `rec_valid` and `rec_ready` are both high. The device may hold `rec_valid` low for any number of cycles, and the copy then waits.

Top module: `snap_fifo_top`

## Requirements
- R1: After reset, offset 0 reads 0x00, offset 1 reads 0x00, offset 3 reads 0x00, offset 2 reads 0x00, and `dma_mode` is low.
- R2: Offset 0 bits [4:0] hold a two's-complement rate code n. When n is negative, a copy starts on the sample tick that completes each run of 2^|n| ticks (|n| is capped at 8). The run is counted from the last write to offset 0.
- R3: When n is zero or positive, no copy ever starts. `dma_mode` is high exactly when n is positive.
- R4: A copy accepts exactly `REC_LEN` bytes over the stream. `rec_ready` is high only while the copy runs, and the copy waits through cycles where `rec_valid` is low.
- R5: The status byte at offset 3 has busy at bit 0, freeze at bit 1 and not-empty at bit 2. Bits 7:3 read zero.
- R6: Busy goes high on the clock edge where the interval expires. It stays high until the edge that accepts the last byte.
- R7: Each read at offset 2 returns the oldest unread byte and removes it. Bytes come out in the order they were received. A read at offset 2 while the FIFO is empty returns 0x00 and changes nothing.
- R8: Starting a copy discards every unread byte. If a pop lands in the same cycle as a copy start, the discard wins, and the host then reads the whole new record from its first byte.
- R9: Freeze is bit 0 of offset 1. A copy already running when freeze is set still completes. No copy starts while freeze is set, and a freeze write in the same cycle as an interval expiry cancels that copy.
- R10: The interval count is held at zero while freeze is set. After freeze is cleared, a full 2^|n| ticks must pass before the next copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle base sample tick |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops at offset 2) |
| host_addr | input | 2 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from offset |
| rec_valid | input | 1 | Device record byte valid |
| rec_ready | output | 1 | Block accepts a record byte |
| rec_data | input | 8 | Device record byte |
| dma_mode | output | 1 | Rate code is positive |

## Verification
Two pairs of events can fall in the same cycle, and each pair is forced on purpose. In the first, the bench drives a sample tick that completes the interval together with a host write that sets freeze. It then checks that busy never rises and that the FIFO stays empty. In the second, the interval expires while the host pops offset 2. The popped byte must be the old record's next byte, and the FIFO must afterwards hold exactly the new record, starting from its first byte.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int RATE_W   = 5;
  localparam int EXP_MAX  = 8;
  localparam int TIMER_W  = EXP_MAX + 1;

  typedef enum logic [1:0] {
    OFF_RATE   = 2'd0,
    OFF_CTRL   = 2'd1,
    OFF_DATA   = 2'd2,
    OFF_STATUS = 2'd3
  } host_off_e;

  // Magnitude of a signed rate code, capped at EXP_MAX
  function automatic logic [3:0] rate_exp(input logic [RATE_W-1:0] code);
    logic [RATE_W:0] wide;
    logic [RATE_W:0] mag;
    wide = {code[RATE_W-1], code};
    mag  = code[RATE_W-1] ? (~wide + 1'b1) : wide;
    return (mag > (RATE_W+1)'(EXP_MAX)) ? 4'(EXP_MAX) : mag[3:0];
  endfunction
endpackage

// File: rtl/snap_interval_timer.sv
module snap_interval_timer #(
  parameter int CW = snap_pkg::TIMER_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       clear,
  input  logic       enable,
  input  logic [3:0] exp_sel,
  output logic       expire
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = (CW'(1) << exp_sel) - CW'(1);
  assign expire = tick && enable && !clear && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear || !enable) cnt_q <= '0;
    else if (tick)             cnt_q <= expire ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/snap_copy_engine.sv
module snap_copy_engine #(
  parameter int REC_LEN = 16,
  parameter int IW      = $clog2(REC_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rec_valid,
  output logic rec_ready,
  output logic busy,
  output logic wr_en
);
  logic [IW-1:0] cnt_q;
  logic          busy_q;
  logic          last_beat;

  assign busy      = busy_q;
  assign rec_ready = busy_q;
  assign wr_en     = busy_q && rec_valid;
  assign last_beat = wr_en && (cnt_q == IW'(REC_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (wr_en) begin
      cnt_q <= cnt_q + IW'(1);
      if (last_beat) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/snap_record_fifo.sv
module snap_record_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int IW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          not_empty,
  output logic [IW-1:0] fill
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] wptr_q, rptr_q;
  logic          do_wr;

  assign do_wr     = wr_en && (wptr_q != IW'(DEPTH));
  assign not_empty = rptr_q < wptr_q;
  assign head      = mem[rptr_q[AW-1:0]];
  assign fill      = wptr_q;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_wr)            wptr_q <= wptr_q + IW'(1);
      if (pop && not_empty) rptr_q <= rptr_q + IW'(1);
    end
  end
endmodule

// File: rtl/snap_fifo_top.sv
module snap_fifo_top #(
  parameter int REC_LEN = 16,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_tick,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [1:0]    host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          rec_valid,
  output logic          rec_ready,
  input  logic [DW-1:0] rec_data,
  output logic          dma_mode
);
  import snap_pkg::*;
  localparam int IW = $clog2(REC_LEN + 1);

  logic [RATE_W-1:0] rate_q;
  logic              freeze_q;
  logic              rate_wr, ctrl_wr, frz_eff;
  logic              expire, start, busy_w, wr_en, pop, not_empty;
  logic [DW-1:0]     head;
  logic [IW-1:0]     fill;

  assign rate_wr  = host_wr && (host_addr == OFF_RATE);
  assign ctrl_wr  = host_wr && (host_addr == OFF_CTRL);
  assign frz_eff  = ctrl_wr ? host_wdata[0] : freeze_q;
  assign start    = expire && !busy_w;
  assign pop      = host_rd && (host_addr == OFF_DATA);
  assign dma_mode = !rate_q[RATE_W-1] && (rate_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q   <= '0;
      freeze_q <= 1'b0;
    end else begin
      if (rate_wr) rate_q   <= host_wdata[RATE_W-1:0];
      if (ctrl_wr) freeze_q <= host_wdata[0];
    end
  end

  snap_interval_timer #(.CW(TIMER_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sample_tick),
    .clear   (frz_eff || rate_wr),
    .enable  (rate_q[RATE_W-1]),
    .exp_sel (rate_exp(rate_q)),
    .expire  (expire)
  );

  snap_copy_engine #(.REC_LEN(REC_LEN), .IW(IW)) u_copy (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .busy      (busy_w),
    .wr_en     (wr_en)
  );

  snap_record_fifo #(.DEPTH(REC_LEN), .DW(DW), .IW(IW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (start),
    .wr_en     (wr_en),
    .wr_data   (rec_data),
    .pop       (pop),
    .head      (head),
    .not_empty (not_empty),
    .fill      (fill)
  );

  always_comb begin
    case (host_addr)
      OFF_RATE:   host_rdata = 8'({rate_q});
      OFF_CTRL:   host_rdata = {7'b0, freeze_q};
      OFF_DATA:   host_rdata = not_empty ? 8'(head) : 8'h00;
      default:    host_rdata = {5'b0, not_empty, freeze_q, busy_w};
    endcase
  end
endmodule

// File: rtl/snap_fifo_chk.sv
module snap_fifo_chk #(
  parameter int REC_LEN = 16,
  parameter int IW      = $clog2(REC_LEN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          freeze,
  input logic          not_empty,
  input logic          rate_neg,
  input logic [1:0]    addr,
  input logic [7:0]    rdata,
  input logic [IW-1:0] fill
);
  AST_STATUS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd3) |-> (rdata[7:3] == 5'b0)); // R5
  AST_FROZEN_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !busy) |=> !busy); // R9
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd2 && !not_empty) |-> (rdata == 8'h00)); // R7
  AST_OFF_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_neg && !busy) |=> !busy); // R3
  AST_START_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !not_empty); // R8
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= IW'(REC_LEN)); // R4
endmodule

bind snap_fifo_top snap_fifo_chk #(.REC_LEN(REC_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy_w),
  .freeze    (freeze_q),
  .not_empty (not_empty),
  .rate_neg  (rate_q[4]),
  .addr      (host_addr),
  .rdata     (host_rdata),
  .fill      (fill)
);

// File: tb/snap_fifo_top_bench.sv
module snap_fifo_top_bench;
  localparam int REC = 16;

  logic clk = 0, rst_n = 0, tick = 0, host_wr = 0, host_rd = 0, rec_valid = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata, rec_data;
  logic rec_ready, dma_mode;
  logic [3:0] gen = 0, idx = 0;
  int errs = 0, checks = 0;

  always #4 clk = ~clk;

  assign rec_data = {gen, idx};
  always @(posedge clk) if (rec_valid && rec_ready) begin
    if (idx == 4'(REC - 1)) begin idx <= 0; gen <= gen + 1; end
    else idx <= idx + 1;
  end

  snap_fifo_top #(.REC_LEN(REC)) u_snap_fifo_top (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data), .dma_mode(dma_mode));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); host_rd = 1; host_addr = a; #1 d = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string req, input logic [3:0] g);
    logic [7:0] d;
    for (int i = 0; i < REC; i++) begin
      rd(2'd2, d);
      check(req, d, {g, 4'(i)});
    end
    rd(2'd2, d); check("R7 empty read", d, 0);
    rd(2'd3, d); check("R7 not-empty low", d[2], 0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); check("R1 rate", d, 0);
    rd(2'd1, d); check("R1 ctrl", d, 0);
    rd(2'd3, d); check("R1 status", d, 0);
    rd(2'd2, d); check("R1 data", d, 0);
    check("R1 dma_mode", dma_mode, 0);
  endtask

  task automatic t_off_modes();
    logic [7:0] d;
    rec_valid = 1;
    ticks(20);
    rd(2'd3, d); check("R3 off no update", d, 0);
    wr(2'd0, 8'd3); check("R3 dma_mode set", dma_mode, 1);
    ticks(20);
    rd(2'd3, d); check("R3 positive no update", d, 0);
    check("R3 no stream", rec_ready, 0);
  endtask

  task automatic t_period();
    logic [7:0] d;
    wr(2'd0, 8'h1E); // n = -2, period 4
    check("R3 dma_mode clear", dma_mode, 0);
    ticks(3);
    rd(2'd3, d); check("R2 no update before period", d, 0);
    ticks(1);
    rd(2'd3, d); check("R6 busy after expiry", d[0], 1);
    idle(20);
    rd(2'd3, d); check("R5 R6 status after copy", d, 8'h04);
  endtask

  task automatic t_freeze_read();
    logic [7:0] d;
    wr(2'd1, 8'h01);
    rd(2'd3, d); check("R5 freeze bit", d, 8'h06);
    drain("R7 record order", gen - 1);
    ticks(12);
    rd(2'd3, d); check("R9 no update frozen", d, 8'h02);
  endtask

  task automatic t_freeze_midcopy();
    logic [7:0] d;
    rec_valid = 0;
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h1F); // n = -1, period 2
    ticks(2);
    rd(2'd3, d); check("R4 stalled copy busy", d, 8'h01);
    @(negedge clk); rec_valid = 1; idle(5); rec_valid = 0;
    wr(2'd1, 8'h01);
    rd(2'd3, d); check("R9 busy during freeze", d, 8'h07);
    ticks(4);
    rec_valid = 1; idle(20);
    rd(2'd3, d); check("R9 copy completes", d, 8'h06);
    check("R4 ready low after copy", rec_ready, 0);
    drain("R4 full record", gen - 1);
  endtask

  task automatic t_flush_collide();
    logic [7:0] d;
    logic [3:0] g0;
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h1F);
    ticks(2); idle(20);
    g0 = gen - 1;
    for (int i = 0; i < 3; i++) begin
      rd(2'd2, d); check("R7 partial read", d, {g0, 4'(i)});
    end
    ticks(1);
    @(negedge clk); tick = 1; host_rd = 1; host_addr = 2; #1 d = host_rdata;
    @(negedge clk); tick = 0; host_rd = 0;
    check("R8 pop at start gets old byte", d, {g0, 4'd3});
    idle(20);
    wr(2'd1, 8'h01);
    drain("R8 flushed new record", g0 + 1);
  endtask

  task automatic t_freeze_expiry_collide();
    logic [7:0] d;
    wr(2'd1, 8'h00);
    ticks(1);
    @(negedge clk); tick = 1; host_wr = 1; host_addr = 1; host_wdata = 8'h01;
    @(negedge clk); tick = 0; host_wr = 0;
    idle(5);
    rd(2'd3, d); check("R9 freeze same-cycle cancels", d, 8'h02);
  endtask

  task automatic t_restart();
    logic [7:0] d;
    wr(2'd0, 8'h1E); // period 4
    wr(2'd1, 8'h00);
    ticks(2);
    wr(2'd1, 8'h01);
    wr(2'd1, 8'h00);
    ticks(3);
    rd(2'd3, d); check("R10 restart from zero", d, 8'h00);
    ticks(1);
    rd(2'd3, d); check("R10 R2 update after full period", d[0], 1);
  endtask

  initial begin
    #(8 * 200000);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    t_reset();
    t_off_modes();
    t_period();
    t_freeze_read();
    t_freeze_midcopy();
    t_flush_collide();
    t_freeze_expiry_collide();
    t_restart();
    idle(25);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule